// File: doc/BRIEF.md
# Clock Victim Selector

This block picks which physical frame to give up when a new page must come into memory. It approximates least-recently-used ordering with a rotating hand over a ring of frames. For every frame it holds a recently-used flag and a modified flag. Each memory access is reported on a reference port. The access sets the frame's used flag, and a write also sets its modified flag.

When a replacement is requested, the search runs in two passes. The first pass goes once round the ring from the hand. It changes nothing and looks only for a frame that is neither used nor modified. If that pass finds no such frame, the second pass runs a classic clock sweep. It clears the used flag of each frame it passes and stops at the first frame whose used flag is already clear. It then reports whether that frame is modified. The hand stops just past the victim. Once the new page is in place, the owner pulses the install port, which resets both flags of that frame.

Top module: `clock_victim_sel`

## Requirements
- R1: A reference with `ref_valid` high sets the used flag of frame `ref_idx` at the next clock edge. If `ref_write` is also high, the same edge sets that frame's modified flag. Frames whose used flag is set are never chosen by the first pass.
- R2: An install pulse clears both flags of frame `install_idx`. If a reference to the same frame arrives in the same cycle, the reference wins, so the used flag ends up set and the modified flag equals `ref_write`.
- R3: A request is accepted only while `busy` is low. `busy` is high from the edge that accepts the request until the edge that reports the victim. `victim_valid` is a one-cycle pulse during which `busy` is already low. Requests that arrive while `busy` is high are ignored and start no further search.
- R4: The first pass probes frames hand, hand+1, … (modulo the frame count), one per cycle. It selects the first frame with both flags clear and reports `victim_dirty` = 0. This pass leaves every used flag and the hand unchanged.
- R5: If the first pass fails, the second pass starts at the hand. For each frame in turn, a set used flag is cleared and the hand moves on. The first frame found with its used flag clear becomes the victim, and `victim_dirty` reports that frame's modified flag.
- R6: The hand is 0 after reset. After each victim is chosen, the hand points to (victim+1) modulo the frame count.
- R7: If a reference hits the frame that the second pass is clearing in the same cycle, the set wins and the frame stays used. A frame referenced on every cycle of a search is therefore never selected.
- R8: Let the request be sampled at edge E0. A first-pass hit at offset k from the hand is reported after edge E(k+1). A second-pass hit at offset j is reported after edge E(N+j+1), where N is the frame count. With no references during the search, j ≤ N.
- R9: After reset, `busy` and `victim_valid` are low and all flags are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid | input | 1 | A frame was accessed this cycle |
| ref_idx | input | IDX_W | Frame that was accessed |
| ref_write | input | 1 | The access was a write |
| install_valid | input | 1 | A new page was placed in a frame |
| install_idx | input | IDX_W | Frame that received the new page |
| repl_req | input | 1 | Request to choose a victim |
| busy | output | 1 | Search in progress |
| victim_valid | output | 1 | One-cycle pulse: victim reported |
| victim_idx | output | IDX_W | Chosen frame |
| victim_dirty | output | 1 | Chosen frame holds modified data |

## Verification
The hardest case to reach from the ports is a reference that lands on exactly the frame the clearing pass is processing in that cycle. A sweep cannot be steered cycle by cycle from outside. The stimulus therefore marks every frame used and modified, then keeps a reference to the hand's frame asserted for the whole search. This forces the clearing pass over that frame twice and requires the set to win both times, so the victim must be the next frame after a full revolution plus one. A long pseudo-random sequence of references, installs and install/reference collisions follows. It is checked against a behavioural model of the two passes that also predicts the exact report cycle.

// File: rtl/clk_repl_pkg.sv
package clk_repl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PROBE = 2'd1,
        PH_SWEEP = 2'd2
    } scan_phase_e;

endpackage

// File: rtl/frame_flags.sv
module frame_flags #(
    parameter int NUM_FRAMES = 16,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ref_valid,
    input  logic [IDX_W-1:0]      ref_idx,
    input  logic                  ref_write,
    input  logic                  install_valid,
    input  logic [IDX_W-1:0]      install_idx,
    input  logic                  clear_en,
    input  logic [IDX_W-1:0]      clear_idx,
    output logic [NUM_FRAMES-1:0] use_o,
    output logic [NUM_FRAMES-1:0] dirty_o
);

    logic [NUM_FRAMES-1:0] use_d, use_q;
    logic [NUM_FRAMES-1:0] dirty_d, dirty_q;

    // Per-frame next state: clears first, reference set last so it wins.
    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
        logic hit_ref, hit_inst, hit_clr;
        assign hit_ref  = ref_valid     && (ref_idx     == IDX_W'(g));
        assign hit_inst = install_valid && (install_idx == IDX_W'(g));
        assign hit_clr  = clear_en      && (clear_idx   == IDX_W'(g));

        always_comb begin
            use_d[g]   = use_q[g];
            dirty_d[g] = dirty_q[g];
            if (hit_inst) begin
                use_d[g]   = 1'b0;
                dirty_d[g] = 1'b0;
            end
            if (hit_clr) begin
                use_d[g] = 1'b0;
            end
            if (hit_ref) begin
                use_d[g] = 1'b1;
                if (ref_write) begin
                    dirty_d[g] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            use_q   <= '0;
            dirty_q <= '0;
        end else begin
            use_q   <= use_d;
            dirty_q <= dirty_d;
        end
    end

    assign use_o   = use_q;
    assign dirty_o = dirty_q;

    p_ref_sets_use_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(ref_valid) |-> use_q[$past(ref_idx)]);

    p_write_sets_dirty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(ref_valid) && $past(ref_write) |-> dirty_q[$past(ref_idx)]);

    p_install_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(install_valid)
        && !($past(ref_valid) && ($past(ref_idx) == $past(install_idx)))
        |-> !use_q[$past(install_idx)] && !dirty_q[$past(install_idx)]);

    p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(clear_en) && $past(ref_valid)
        && ($past(ref_idx) == $past(clear_idx))
        |-> use_q[$past(clear_idx)]);

endmodule

// File: rtl/victim_scanner.sv
module victim_scanner
    import clk_repl_pkg::*;
#(
    parameter int NUM_FRAMES = 16,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic [NUM_FRAMES-1:0] use_i,
    input  logic [NUM_FRAMES-1:0] dirty_i,
    output logic                  clear_en,
    output logic [IDX_W-1:0]      clear_idx,
    output scan_phase_e           phase_o,
    output logic                  busy,
    output logic                  victim_valid,
    output logic [IDX_W-1:0]      victim_idx,
    output logic                  victim_dirty
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

    typedef struct packed {
        scan_phase_e      phase;
        logic [IDX_W-1:0] hand;
        logic [IDX_W-1:0] step;
        logic             vld;
        logic [IDX_W-1:0] vidx;
        logic             vdirty;
    } scan_t;

    scan_t s_d, s_q;

    function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [IDX_W-1:0] ring_add(input logic [IDX_W-1:0] a,
                                                  input logic [IDX_W-1:0] b);
        logic [IDX_W:0] sum;
        sum = {1'b0, a} + {1'b0, b};
        if (sum >= (IDX_W+1)'(NUM_FRAMES)) begin
            sum = sum - (IDX_W+1)'(NUM_FRAMES);
        end
        return sum[IDX_W-1:0];
    endfunction

    logic [IDX_W-1:0] probe_idx;
    assign probe_idx = ring_add(s_q.hand, s_q.step);

    always_comb begin
        s_d       = s_q;
        s_d.vld   = 1'b0;
        clear_en  = 1'b0;
        clear_idx = s_q.hand;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (req) begin
                    s_d.phase = PH_PROBE;
                    s_d.step  = '0;
                end
            end
            PH_PROBE: begin
                if (!use_i[probe_idx] && !dirty_i[probe_idx]) begin
                    s_d.phase  = PH_IDLE;
                    s_d.vld    = 1'b1;
                    s_d.vidx   = probe_idx;
                    s_d.vdirty = 1'b0;
                    s_d.hand   = ring_next(probe_idx);
                end else if (s_q.step == LAST_IDX) begin
                    s_d.phase = PH_SWEEP;
                    s_d.step  = '0;
                end else begin
                    s_d.step = s_q.step + 1'b1;
                end
            end
            PH_SWEEP: begin
                if (!use_i[s_q.hand]) begin
                    s_d.phase  = PH_IDLE;
                    s_d.vld    = 1'b1;
                    s_d.vidx   = s_q.hand;
                    s_d.vdirty = dirty_i[s_q.hand];
                    s_d.hand   = ring_next(s_q.hand);
                end else begin
                    clear_en = 1'b1;
                    s_d.hand = ring_next(s_q.hand);
                end
            end
            default: begin
                s_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o      = s_q.phase;
    assign busy         = (s_q.phase != PH_IDLE);
    assign victim_valid = s_q.vld;
    assign victim_idx   = s_q.vidx;
    assign victim_dirty = s_q.vdirty;

    p_leave_only_with_victim_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_IDLE) |=> (s_q.phase != PH_IDLE) || s_q.vld);

    p_hand_after_victim_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.vld |-> s_q.hand == ring_next(s_q.vidx));

    p_probe_keeps_hand_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_PROBE) |=> s_q.vld || (s_q.hand == $past(s_q.hand)));

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel
    import clk_repl_pkg::*;
#(
    parameter int NUM_FRAMES = 16,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_valid,
    input  logic [IDX_W-1:0] ref_idx,
    input  logic             ref_write,
    input  logic             install_valid,
    input  logic [IDX_W-1:0] install_idx,
    input  logic             repl_req,
    output logic             busy,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_idx,
    output logic             victim_dirty
);

    logic [NUM_FRAMES-1:0] use_vec;
    logic [NUM_FRAMES-1:0] dirty_vec;
    logic                  clr_en;
    logic [IDX_W-1:0]      clr_idx;
    scan_phase_e           scan_phase;

    frame_flags #(
        .NUM_FRAMES(NUM_FRAMES),
        .IDX_W     (IDX_W)
    ) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_valid    (ref_valid),
        .ref_idx      (ref_idx),
        .ref_write    (ref_write),
        .install_valid(install_valid),
        .install_idx  (install_idx),
        .clear_en     (clr_en),
        .clear_idx    (clr_idx),
        .use_o        (use_vec),
        .dirty_o      (dirty_vec)
    );

    victim_scanner #(
        .NUM_FRAMES(NUM_FRAMES),
        .IDX_W     (IDX_W)
    ) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (repl_req),
        .use_i       (use_vec),
        .dirty_i     (dirty_vec),
        .clear_en    (clr_en),
        .clear_idx   (clr_idx),
        .phase_o     (scan_phase),
        .busy        (busy),
        .victim_valid(victim_valid),
        .victim_idx  (victim_idx),
        .victim_dirty(victim_dirty)
    );

    // First pass never drops a used flag unless an install does it.
    p_probe_no_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_phase == PH_PROBE) && !install_valid |=> &(use_vec | ~$past(use_vec)));

    p_victim_not_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> !busy);

endmodule

// File: tb/sim_clock_victim_sel.sv
module sim_clock_victim_sel;

    localparam int N  = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ref_valid;
    logic [IW-1:0] ref_idx;
    logic          ref_write;
    logic          install_valid;
    logic [IW-1:0] install_idx;
    logic          repl_req;
    logic          busy;
    logic          victim_valid;
    logic [IW-1:0] victim_idx;
    logic          victim_dirty;

    always #4 clk = ~clk;

    clock_victim_sel #(.NUM_FRAMES(N)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ref_valid(ref_valid), .ref_idx(ref_idx), .ref_write(ref_write),
        .install_valid(install_valid), .install_idx(install_idx),
        .repl_req(repl_req), .busy(busy),
        .victim_valid(victim_valid), .victim_idx(victim_idx),
        .victim_dirty(victim_dirty)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 0;
    bit          m_use   [N];
    bit          m_dirty [N];
    int          m_hand;
    int          last_victim;
    int unsigned rs = 32'h1234ABCD;

    function automatic int unsigned rnd();
        rs ^= rs << 13;
        rs ^= rs >> 17;
        rs ^= rs << 5;
        return rs;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural model of the two passes; pin = frame referenced throughout (-1: none)
    task automatic model_pick(input int pin, output int v, output int d, output int lat);
        int found = -1;
        lat = 0;
        for (int k = 0; k < N; k++) begin
            int f = (m_hand + k) % N;
            bit u = m_use[f] || (f == pin);
            if (found < 0 && !u && !m_dirty[f]) begin
                found = f;
                lat   = k + 2;
            end
        end
        if (found < 0) begin
            for (int j = 0; j < 2 * N + 2; j++) begin
                int f = (m_hand + j) % N;
                bit u = m_use[f] || (f == pin);
                if (found < 0) begin
                    if (!u) begin
                        found = f;
                        lat   = N + j + 2;
                    end else begin
                        m_use[f] = 1'b0;
                    end
                end
            end
        end
        v      = found;
        d      = m_dirty[found];
        m_hand = (found + 1) % N;
        if (pin >= 0) m_use[pin] = 1'b1;
    endtask

    task automatic do_ref(input int idx, input bit wr);
        ref_valid = 1'b1;
        ref_idx   = IW'(idx);
        ref_write = wr;
        @(negedge clk);
        ref_valid = 1'b0;
        ref_write = 1'b0;
        m_use[idx] = 1'b1;
        if (wr) m_dirty[idx] = 1'b1;
    endtask

    task automatic do_install(input int idx, input bit collide, input bit wr);
        install_valid = 1'b1;
        install_idx   = IW'(idx);
        if (collide) begin
            ref_valid = 1'b1;
            ref_idx   = IW'(idx);
            ref_write = wr;
        end
        @(negedge clk);
        install_valid = 1'b0;
        ref_valid     = 1'b0;
        ref_write     = 1'b0;
        m_use[idx]   = collide;
        m_dirty[idx] = collide && wr;
    endtask

    task automatic do_request(input string tag, input int pin, input bit extra);
        int ev, ed, el, cnt;
        model_pick(pin, ev, ed, el);
        if (pin >= 0) begin
            ref_valid = 1'b1;
            ref_idx   = IW'(pin);
            ref_write = 1'b0;
        end
        repl_req = 1'b1;
        @(negedge clk);
        repl_req = 1'b0;
        cnt = 1;
        check({tag, " R3 busy after accept"}, int'(busy), 1);
        while (!victim_valid && cnt < 4 * N + 8) begin
            repl_req = extra && (cnt == 1);
            @(negedge clk);
            repl_req = 1'b0;
            cnt++;
        end
        ref_valid = 1'b0;
        check({tag, " R4 R5 R6 victim index"}, int'(victim_idx), ev);
        check({tag, " R5 victim dirty"}, int'(victim_dirty), ed);
        check({tag, " R8 report cycle"}, cnt, el);
        check({tag, " R3 busy low with victim"}, int'(busy), 0);
        last_victim = ev;
        @(negedge clk);
        check({tag, " R3 single pulse"}, int'(victim_valid), 0);
        check({tag, " R3 no restart"}, int'(busy), 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ref_valid = 1'b0; ref_idx = '0; ref_write = 1'b0;
        install_valid = 1'b0; install_idx = '0; repl_req = 1'b0;
        for (int i = 0; i < N; i++) begin
            m_use[i] = 1'b0;
            m_dirty[i] = 1'b0;
        end
        m_hand = 0;
        last_victim = 0;
        repeat (3) @(negedge clk);
        check("R9 reset busy", int'(busy), 0);
        check("R9 reset victim_valid", int'(victim_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        do_request("R9 first request", -1, 1'b0);

        do_ref(1, 1'b1);
        do_ref(2, 1'b0);
        do_request("R1 skip referenced", -1, 1'b0);

        for (int i = 0; i < N; i++) do_ref(i, 1'b0);
        do_request("R5 all used", -1, 1'b0);

        for (int i = 0; i < N; i++) do_ref(i, 1'b1);
        do_install(9, 1'b0, 1'b0);
        do_request("R2 install clean", -1, 1'b0);

        for (int i = 0; i < N; i++) do_ref(i, 1'b0);
        do_install(4, 1'b1, 1'b1);
        do_request("R2 install collide", -1, 1'b0);

        for (int i = 0; i < N; i++) do_ref(i, 1'b1);
        do_request("R7 pinned hand", m_hand, 1'b1);

        for (int t = 0; t < 300; t++) begin
            int unsigned r = rnd();
            int nref = int'(r % 7);
            for (int k = 0; k < nref; k++) begin
                int unsigned q = rnd();
                do_ref(int'(q % N), q[20]);
            end
            if (r[8]) do_install(last_victim, r[9], r[10]);
            do_request("R1 R2 sweep", -1, r[11]);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule